// File: doc/BRIEF.md
# Dual-Rail Power-On Reset Timer

This block produces the system reset for a pair of regulated supply rails. It watches one digital "rail good" flag per rail (the output of an analog comparator that reads high while the rail sits above 90% of its target), a soft-start-finished signal, a converter enable and an undervoltage-lockout signal. The reset line is open-drain. The block holds the line low until every release condition has been met continuously for a programmable timeout. It lets go of the line only after that.

The timeout is counted in two stages. A prescaler divides the system clock into a slow tick, and a tick counter then counts a set number of those ticks. The comparator flags arrive asynchronously, so each one passes through a two-flop synchronizer. The good threshold has no hysteresis. A single sampled cycle with a rail flag low pulls reset low at once and discards any progress already made toward release. The default parameters give a delay of about 315 ms with a 1 MHz clock.

Top module: `rail_por_timer`

## Requirements
- R1: While `rst_n` is low and after it is released, `por_pull_low` is 1 (reset driven low) until the release timeout has completed.
- R2: The block is qualified only when `enable` is 1, `uvlo` is 0, `ss_done` is 1 and every synchronized rail flag is 1; no count progresses while any of these is missing.
- R3: Each bit of `rail_good_raw` goes through two flip-flops; a change on a raw flag sampled at one rising edge affects qualification from the second rising edge onward.
- R4: `por_pull_low` goes to 0 right after the rising edge that completes DIV_CYCLES*TIMEOUT_TICKS consecutive qualified edges, and it stays 0 while qualification holds.
- R5: A synchronized rail flag that is low for a single cycle drives `por_pull_low` to 1 in that same cycle, with no hysteresis.
- R6: Losing qualification at any point, before or after release, resets the count, so the next release needs the full DIV_CYCLES*TIMEOUT_TICKS qualified edges again.
- R7: `enable` low or `uvlo` high forces `por_pull_low` to 1 combinationally, in the same cycle and without waiting for a clock edge.
- R8: With `ss_done` low, both rails good and `enable` high, `por_pull_low` stays 1 for any length of time.
- R9: `por_pull_low` is the open-drain control: 1 means the pin is pulled low (reset asserted) and 0 means the pin is left high-impedance (reset released).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| enable | input | 1 | Converter enable, synchronous to clk |
| uvlo | input | 1 | Undervoltage lockout active, synchronous to clk |
| ss_done | input | 1 | Soft-start finished, synchronous to clk |
| rail_good_raw | input | NUM_RAILS | Per-rail comparator flags (asynchronous), 1 = rail above 90% |
| por_pull_low | output | 1 | Open-drain control: 1 pulls reset low, 0 releases the pin |

## Verification
The bench builds the block with DIV_CYCLES = 4 and TIMEOUT_TICKS = 5, so a full release takes 20 qualified edges and the whole sequence can be traced cycle by cycle. With these values the bench can place a dropout on the last edge before release, one edge after release, and on a prescaler boundary. It can also land a one-cycle raw glitch at each position inside a tick, and it can fit long soft-start holds and repeated enable and lockout toggles into a short run. The default timeout would put most of these cases out of reach.

// File: rtl/por_pkg.sv
package por_pkg;

  typedef enum logic {
    PST_HOLD     = 1'b0,
    PST_RELEASED = 1'b1
  } por_state_e;

endpackage

// File: rtl/por_flag_sync.sv
module por_flag_sync #(
  parameter int unsigned NUM_FLAGS = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_FLAGS-1:0] flag_async,
  output logic [NUM_FLAGS-1:0] flag_sync
);

  logic [NUM_FLAGS-1:0] meta_q;
  logic [NUM_FLAGS-1:0] stab_q;

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_chan
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[g] <= 1'b0;
        stab_q[g] <= 1'b0;
      end else begin
        meta_q[g] <= flag_async[g];
        stab_q[g] <= meta_q[g];
      end
    end
  end

  assign flag_sync = stab_q;

endmodule

// File: rtl/por_tick_gen.sv
module por_tick_gen #(
  parameter int unsigned DIV_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  localparam int unsigned DW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [DW-1:0] DIV_MAX = DW'(DIV_CYCLES - 1);

  logic [DW-1:0] div_q;
  logic [DW-1:0] div_d;
  logic          div_en;
  logic          at_max;

  assign at_max = (div_q == DIV_MAX);
  assign tick   = run && at_max;

  always_comb begin
    div_en = 1'b1;
    div_d  = div_q;
    if (!run) begin
      div_d = '0;
    end else if (at_max) begin
      div_d = '0;
    end else begin
      div_d = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
    end else if (div_en) begin
      div_q <= div_d;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    div_q <= DIV_MAX); // R4

  AST_DIV_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (div_q == '0)); // R6

endmodule

// File: rtl/por_release_timer.sv
module por_release_timer
  import por_pkg::*;
#(
  parameter int unsigned TIMEOUT_TICKS = 315
) (
  input  logic clk,
  input  logic rst_n,
  input  logic qualified,
  input  logic tick,
  output logic released
);

  localparam int unsigned TW = (TIMEOUT_TICKS > 1) ? $clog2(TIMEOUT_TICKS) : 1;
  localparam logic [TW-1:0] TICK_MAX = TW'(TIMEOUT_TICKS - 1);

  por_state_e    state_q;
  por_state_e    state_d;
  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] tcnt_d;
  logic          tcnt_en;

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    tcnt_en = 1'b0;
    if (!qualified) begin
      state_d = PST_HOLD;
      tcnt_d  = '0;
      tcnt_en = 1'b1;
    end else begin
      case (state_q)
        PST_HOLD: begin
          if (tick) begin
            tcnt_en = 1'b1;
            if (tcnt_q == TICK_MAX) begin
              state_d = PST_RELEASED;
              tcnt_d  = '0;
            end else begin
              tcnt_d = tcnt_q + 1'b1;
            end
          end
        end
        PST_RELEASED: begin
          state_d = PST_RELEASED;
        end
        default: begin
          state_d = PST_HOLD;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PST_HOLD;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tcnt_q <= '0;
    end else if (tcnt_en) begin
      tcnt_q <= tcnt_d;
    end
  end

  assign released = (state_q == PST_RELEASED);

  AST_TICK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tcnt_q <= TICK_MAX); // R4

  AST_RELEASE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(released) |-> $past(tick && qualified)); // R4

  AST_DROP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !qualified |=> (!released && tcnt_q == '0)); // R6

  AST_RELEASE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (released && qualified) |=> released); // R4

endmodule

// File: rtl/rail_por_timer.sv
module rail_por_timer #(
  parameter int unsigned NUM_RAILS     = 2,
  parameter int unsigned DIV_CYCLES    = 1000,
  parameter int unsigned TIMEOUT_TICKS = 315
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 uvlo,
  input  logic                 ss_done,
  input  logic [NUM_RAILS-1:0] rail_good_raw,
  output logic                 por_pull_low
);

  logic [NUM_RAILS-1:0] rail_good_s;
  logic                 all_rails_good;
  logic                 qualified;
  logic                 tick;
  logic                 released;

  por_flag_sync #(
    .NUM_FLAGS (NUM_RAILS)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .flag_async (rail_good_raw),
    .flag_sync  (rail_good_s)
  );

  assign all_rails_good = &rail_good_s;
  assign qualified      = enable && !uvlo && ss_done && all_rails_good;

  por_tick_gen #(
    .DIV_CYCLES (DIV_CYCLES)
  ) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (qualified && !released),
    .tick  (tick)
  );

  por_release_timer #(
    .TIMEOUT_TICKS (TIMEOUT_TICKS)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .qualified (qualified),
    .tick      (tick),
    .released  (released)
  );

  assign por_pull_low = !(released && qualified);

  always_comb begin
    if (rst_n && (!enable || uvlo)) begin
      AST_FORCE_LOW: assert (por_pull_low); // R7
    end
  end

  AST_SS_GATES: assert property (@(posedge clk) disable iff (!rst_n)
    !ss_done |-> por_pull_low); // R8

  AST_RELEASE_NEEDS_RAILS: assert property (@(posedge clk) disable iff (!rst_n)
    !por_pull_low |-> (&$past(rail_good_raw, 2))); // R3

endmodule

// File: tb/rail_por_timer_test.sv
module rail_por_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int NR         = 2;
  localparam int DIV        = 4;
  localparam int TMO        = 5;
  localparam int LIM        = DIV * TMO;

  logic          clk;
  logic          rst_n;
  logic          enable;
  logic          uvlo;
  logic          ss_done;
  logic [NR-1:0] rail_good_raw;
  logic          por_pull_low;

  int n_cmp;
  int n_bad;
  int cycles;
  string phase;

  // behavioural reference
  logic [NR-1:0] m_s1, m_s2;
  int            m_run;
  bit            m_rel;

  rail_por_timer #(
    .NUM_RAILS     (NR),
    .DIV_CYCLES    (DIV),
    .TIMEOUT_TICKS (TMO)
  ) uut (
    .clk           (clk),
    .rst_n         (rst_n),
    .enable        (enable),
    .uvlo          (uvlo),
    .ss_done       (ss_done),
    .rail_good_raw (rail_good_raw),
    .por_pull_low  (por_pull_low)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit qual_now();
    return enable && !uvlo && ss_done && (m_s2 == {NR{1'b1}});
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_run = 0; m_rel = 0;
    end else begin
      if (qual_now()) m_run = m_run + 1;
      else            m_run = 0;
      m_rel = (m_run >= LIM);
      m_s2 = m_s1;
      m_s1 = rail_good_raw;
    end
  end

  // compare on every falling edge, before inputs move
  always @(negedge clk) begin
    bit exp;
    cycles++;
    exp = !(m_rel && qual_now());
    n_cmp++;
    if (por_pull_low !== exp) begin
      n_bad++;
      $display("FAIL %s: por_pull_low=%0b expected=%0b at cycle %0d",
               phase, por_pull_low, exp, cycles);
    end
  end

  // directed point check, sampled away from the edge
  task automatic expect_pin(input string tag, input bit exp);
    #1;
    n_cmp++;
    if (por_pull_low !== exp) begin
      n_bad++;
      $display("FAIL %s: por_pull_low=%0b expected=%0b", tag, por_pull_low, exp);
    end
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic all_good();
    enable = 1; uvlo = 0; ss_done = 1; rail_good_raw = '1;
  endtask

  initial begin
    phase = "R1 reset"; rst_n = 0; enable = 0; uvlo = 1; ss_done = 0; rail_good_raw = '0;
    step(3);
    expect_pin("R1 in reset", 1'b1);
    rst_n = 1; step(2);
    expect_pin("R1 after reset", 1'b1);

    // R4: clean release, 2 sync edges + LIM qualified edges
    phase = "R4 release"; all_good();
    step(2 + LIM - 1);
    expect_pin("R4 one edge early", 1'b1);
    step(1);
    expect_pin("R4 released", 1'b0);
    step(10);
    expect_pin("R4 stays released", 1'b0);

    // R5 / R6: single-cycle raw glitch after release
    phase = "R5 glitch"; rail_good_raw[1] = 0; step(1); rail_good_raw[1] = 1; step(2);
    expect_pin("R5 reasserted", 1'b1);
    phase = "R6 restart"; step(LIM - 2);
    expect_pin("R6 not yet", 1'b1);
    step(2); expect_pin("R6 full count again", 1'b0);

    // R6: dropout on last edge before release, at several offsets
    for (int off = 1; off <= DIV + 1; off++) begin
      phase = "R6 mid-count drop";
      rail_good_raw[0] = 0; step(3); rail_good_raw[0] = 1;
      step(2 + LIM - off);
      rail_good_raw[0] = 0; step(1); rail_good_raw[0] = 1;
      step(LIM + 3);
      expect_pin("R6 released after restart", 1'b0);
    end

    // R8: soft-start gating
    phase = "R8 ss_done low"; ss_done = 0;
    expect_pin("R8 immediate", 1'b1);
    step(3 * LIM);
    expect_pin("R8 held", 1'b1);
    ss_done = 1; step(LIM - 1);
    expect_pin("R8 count after ss", 1'b1);
    step(1); expect_pin("R8 released", 1'b0);

    // R7: enable / uvlo combinational
    phase = "R7 enable"; enable = 0;
    expect_pin("R7 enable low same cycle", 1'b1);
    step(2); enable = 1; step(LIM);
    expect_pin("R7 re-released", 1'b0);
    phase = "R7 uvlo"; uvlo = 1;
    expect_pin("R7 uvlo same cycle", 1'b1);
    step(1); uvlo = 0; step(LIM);
    expect_pin("R7 uvlo recovered", 1'b0);

    // R2 / R3: one rail missing, sync latency
    phase = "R2 one rail"; rail_good_raw = 2'b01; step(1);
    expect_pin("R3 raw not yet seen", 1'b0);
    step(1); expect_pin("R3 seen after two edges", 1'b1);
    step(3 * LIM);
    expect_pin("R2 single rail holds reset", 1'b1);
    rail_good_raw = 2'b10; step(3 * LIM);
    expect_pin("R2 other rail holds reset", 1'b1);

    // R9: pin meaning, with final release
    phase = "R9 final"; rail_good_raw = 2'b11; step(2 + LIM);
    expect_pin("R9 pin released high-Z", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule